// File: doc/BRIEF.md
# Fetch Address Selector with Static Next-Address Prediction

This block sits in the fetch stage of a five-stage in-order pipeline. Each cycle it chooses the address to fetch. It registers a guess of the next fetch address based on the class of the instruction now being fetched. Ordinary instructions fall through to their sequential address. Every jump and every call, conditional or not, is assumed taken, so the guess is the instruction's constant target. A return gets no real guess.

Two later stages can overrule the guess. The first is a conditional jump in the memory stage whose branch flag shows it was not taken. In that case the fetch address is the fall-through address carried alongside that jump. The second is a return in the write-back stage. In that case the fetch address is the return address just loaded from memory. Whenever either source wins, a redirect flag is raised so that a control unit can discard the wrong-path instructions. A stall input freezes the registered guess.

Top module: `fetch_pc_sel`

## Requirements
- R1: When the fetched class is plain (code 0) or any unused code (5 to 7), the registered guess loads the sequential address `f_seq`.
- R2: When the fetched class is unconditional jump (code 1) or call (code 3), the registered guess loads the constant target `f_tgt`.
- R3: When the fetched class is conditional jump (code 2), the registered guess loads `f_tgt`, so the jump is predicted taken.
- R4: When the fetched class is return (code 4), no target is predicted: the registered guess loads `f_seq` and is corrected later by the write-back override.
- R5: When `m_cls` is conditional jump (code 2) and `m_taken` is 0, with no write-back return present, `fetch_pc` equals `m_fall` and `redirect` is 1.
- R6: When `w_cls` is return (code 4), `fetch_pc` equals `w_ret` and `redirect` is 1, even if the R5 condition holds at the same time.
- R7: With neither override active, `fetch_pc` equals the registered guess and `redirect` is 0.
- R8: Reset (`rst_n` low) clears the registered guess to address 0.
- R9: While `stall_f` is 1, the registered guess holds its value.
- R10: A taken conditional jump, or any non-conditional class in the memory stage, does not override, whatever `m_taken` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_f | input | 1 | Hold the registered guess |
| f_cls | input | 3 | Class of the instruction being fetched |
| f_tgt | input | AW | Constant target of the fetched instruction |
| f_seq | input | AW | Sequential next address of the fetched instruction |
| m_cls | input | 3 | Class of the memory-stage instruction |
| m_taken | input | 1 | Branch outcome of the memory-stage instruction |
| m_fall | input | AW | Fall-through address carried in the memory stage |
| w_cls | input | 3 | Class of the write-back-stage instruction |
| w_ret | input | AW | Value loaded from memory in the write-back stage |
| fetch_pc | output | AW | Selected fetch address |
| redirect | output | 1 | An override source supplied `fetch_pc` |

## Verification
The assertions assume that the class inputs stay constant within each cycle. They also assume that `f_tgt` and `f_seq` belong to the instruction whose class is presented. Both assumptions are met because the bench drives every input once per cycle at the falling edge. The prediction checks look only at cycles with no override in the following cycle, since an override hides the registered guess at the port. The stimulus therefore places lone prediction cycles between override cycles, so that each class's guess can be seen directly.

// File: rtl/fetch_pc_sel.sv
module fetch_pc_sel #(
  parameter int AW = 32,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_f,
  input  logic [CW-1:0] f_cls,
  input  logic [AW-1:0] f_tgt,
  input  logic [AW-1:0] f_seq,
  input  logic [CW-1:0] m_cls,
  input  logic          m_taken,
  input  logic [AW-1:0] m_fall,
  input  logic [CW-1:0] w_cls,
  input  logic [AW-1:0] w_ret,
  output logic [AW-1:0] fetch_pc,
  output logic          redirect
);
  localparam logic [CW-1:0] C_JMP  = CW'(1);
  localparam logic [CW-1:0] C_JCC  = CW'(2);
  localparam logic [CW-1:0] C_CALL = CW'(3);
  localparam logic [CW-1:0] C_RET  = CW'(4);

  logic [AW-1:0] guess_q, guess_d;
  logic          uses_tgt, wb_ret, mem_miss;

  assign uses_tgt = (f_cls == C_JMP) || (f_cls == C_JCC) || (f_cls == C_CALL);
  assign guess_d  = uses_tgt ? f_tgt : f_seq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        guess_q <= '0;
    else if (!stall_f) guess_q <= guess_d;

  assign wb_ret   = (w_cls == C_RET);
  assign mem_miss = (m_cls == C_JCC) && !m_taken;

  assign fetch_pc = wb_ret ? w_ret : (mem_miss ? m_fall : guess_q);
  assign redirect = wb_ret || mem_miss;

  p_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && (f_cls == '0)) |=> (redirect || fetch_pc == $past(f_seq)));
  p_tgt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && (f_cls == C_JMP || f_cls == C_CALL)) |=> (redirect || fetch_pc == $past(f_tgt)));
  p_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && f_cls == C_JCC) |=> (redirect || fetch_pc == $past(f_tgt)));
  p_ret_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && f_cls == C_RET) |=> (redirect || fetch_pc == $past(f_seq)));
  p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cls == C_JCC && !m_taken && w_cls != C_RET) |-> (redirect && fetch_pc == m_fall));
  p_wb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cls == C_RET) |-> (redirect && fetch_pc == w_ret));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_f && !redirect) |=> (redirect || $stable(fetch_pc)));
endmodule

// File: tb/tb_fetch_pc_sel.sv
module tb_fetch_pc_sel;
  typedef struct packed {
    logic        stall;
    logic [2:0]  fcls;
    logic [31:0] tgt;
    logic [31:0] seq;
    logic [2:0]  mcls;
    logic        mtak;
    logic [31:0] mfall;
    logic [2:0]  wcls;
    logic [31:0] wret;
    logic [31:0] exp_pc;
    logic        exp_rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0,3'd0,32'h99, 32'h4,  3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h0,  1'b0}, // R8 reset guess, R1 load
    '{1'b0,3'd1,32'h40, 32'h9,  3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h4,  1'b0}, // R1 seen, R2 jmp
    '{1'b0,3'd3,32'h80, 32'h45, 3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h40, 1'b0}, // R2 seen, call
    '{1'b0,3'd2,32'hC0, 32'h85, 3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h80, 1'b0}, // R2 call seen, R3 jcc
    '{1'b0,3'd4,32'h11, 32'hC1, 3'd0,1'b0,32'h0,  3'd0,32'h0,  32'hC0, 1'b0}, // R3 seen, R4 ret
    '{1'b0,3'd0,32'h0,  32'h200,3'd2,1'b0,32'h88, 3'd0,32'h0,  32'h88, 1'b1}, // R5 mispredict
    '{1'b0,3'd0,32'h0,  32'h300,3'd2,1'b1,32'h77, 3'd0,32'h0,  32'h200,1'b0}, // R10 taken jcc
    '{1'b0,3'd0,32'h0,  32'h504,3'd2,1'b0,32'h66, 3'd4,32'h500,32'h500,1'b1}, // R6 priority
    '{1'b1,3'd1,32'h900,32'h0,  3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h504,1'b0}, // R9 stall
    '{1'b0,3'd5,32'h999,32'h50A,3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h504,1'b0}, // R9 held, R1 unused
    '{1'b0,3'd7,32'h0,  32'h600,3'd1,1'b0,32'h123,3'd2,32'h321,32'h50A,1'b0}, // R10 non-jcc, R1
    '{1'b0,3'd0,32'h0,  32'h604,3'd0,1'b0,32'h0,  3'd0,32'h0,  32'h600,1'b0}  // R7 plain
  };

  logic        clk = 0, rst_n = 0, stall_f = 0, m_taken = 0;
  logic [2:0]  f_cls = 0, m_cls = 0, w_cls = 0;
  logic [31:0] f_tgt = 0, f_seq = 0, m_fall = 0, w_ret = 0;
  logic [31:0] fetch_pc;
  logic        redirect;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fetch_pc_sel dut (
    .clk(clk), .rst_n(rst_n), .stall_f(stall_f), .f_cls(f_cls), .f_tgt(f_tgt),
    .f_seq(f_seq), .m_cls(m_cls), .m_taken(m_taken), .m_fall(m_fall),
    .w_cls(w_cls), .w_ret(w_ret), .fetch_pc(fetch_pc), .redirect(redirect)
  );

  function automatic string tag(int i);
    case (i)
      0: return "R8";  1: return "R1";  2: return "R2";  3: return "R2";
      4: return "R3";  5: return "R5";  6: return "R10"; 7: return "R6";
      8: return "R9";  9: return "R9";  10: return "R10"; default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    stall_f = 0; f_cls = 0; f_tgt = 0; f_seq = 0;
    m_cls = 0; m_taken = 0; m_fall = 0; w_cls = 0; w_ret = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R8", fetch_pc, 32'h0);
    chk("R7", {31'b0, redirect}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stall_f = TBL[i].stall; f_cls = TBL[i].fcls; f_tgt = TBL[i].tgt; f_seq = TBL[i].seq;
      m_cls = TBL[i].mcls; m_taken = TBL[i].mtak; m_fall = TBL[i].mfall;
      w_cls = TBL[i].wcls; w_ret = TBL[i].wret;
      #1;
      chk(tag(i), fetch_pc, TBL[i].exp_pc);
      chk(tag(i), {31'b0, redirect}, {31'b0, TBL[i].exp_rd});
    end
    // R4: ret guess is the sequential address, visible once no override is present
    @(negedge clk); idle(); f_cls = 3'd4; f_tgt = 32'hAAA; f_seq = 32'h700;
    @(negedge clk); idle(); #1;
    chk("R4", fetch_pc, 32'h700);
    // R6 override under stall, R9 guess kept behind it
    @(negedge clk); idle(); stall_f = 1; f_cls = 3'd1; f_tgt = 32'hBBB;
    w_cls = 3'd4; w_ret = 32'h840; #1;
    chk("R6", fetch_pc, 32'h840);
    chk("R6", {31'b0, redirect}, 32'h1);
    @(negedge clk); idle(); #1;
    chk("R9", fetch_pc, 32'h0);
    // R8: reset mid-run clears the guess
    @(negedge clk); idle(); f_cls = 3'd1; f_tgt = 32'hCC0;
    @(negedge clk); idle(); #1;
    chk("R2", fetch_pc, 32'hCC0);
    rst_n = 0; #1;
    chk("R8", fetch_pc, 32'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R8", fetch_pc, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule